// File: doc/BRIEF.md
# Converter Serial Result Port

This block is the digital output stage of a data converter. A conversion core hands it a parallel result word together with a one-cycle strobe. The block latches the word, raises a ready flag for the host, and shifts the word out one bit per shift-clock period, most significant bit first. The data line changes on the falling edge of the shift clock, so the host samples it on the rising edge.

The shift clock has two possible sources. The block can divide it down from its master clock, or the host can supply it. A select input chooses between them while the block is in single-ended output mode. Differential mode always uses the internal clock. An active-low chip select allows several ports to share one bus. While it is inactive, the data and clock drivers are switched off and the bit position returns to the most significant bit. The ready flag and its complement stay driven whatever the chip select does.

The block models only the logic behind the pins. Each tri-stated pin is a value plus an enable. The complement outputs are plain logical inverses.

Top module: `adc_sout_if`

## Requirements
- R1: The loaded word appears on `sdo_o` most significant bit first. Each falling shift-clock edge advances one bit, and each bit is stable while the shift clock is high.
- R2: With `clk_sel_i`=0 and `cs_ni` low, `sclk_oe_o` is 1 and `sclk_o` toggles every DIV/2 master-clock cycles. DIV defaults to 2.
- R3: With `clk_sel_i`=1 and `se_mode_i`=1, `sclk_oe_o` is 0. The data then advances on falling edges of `ext_sclk_i`, after a short synchronisation delay.
- R4: With `se_mode_i`=0 (differential mode), the shift clock is generated internally and driven, whatever `clk_sel_i` is.
- R5: While `cs_ni` is 1, `sdo_oe_o` and `sclk_oe_o` are 0 and the internal clock stays low. When `cs_ni` returns to 0, a word that is still pending is sent again from its most significant bit.
- R6: `rdy_o` and `rdy_n_o` are valid at all times, regardless of `cs_ni`, with `rdy_n_o` equal to the inverse of `rdy_o`. `sdo_n_o` equals the inverse of `sdo_o`.
- R7: A `new_word_i` pulse while `rdy_o` is 0 loads `word_i` at that clock edge. `rdy_o` is 1 in the next cycle, and the word's most significant bit is on `sdo_o`.
- R8: `rdy_o` falls on the shift-clock falling edge that ends the least significant bit.
- R9: A `new_word_i` pulse while `rdy_o` is 1 discards the unfinished word. `rdy_o` is 0 for exactly one cycle and then rises again, and the new word is sent from its most significant bit.
- R10: After reset, `rdy_o` is 0, `rdy_n_o` is 1, `sclk_o` is 0, and with `cs_ni` high both output enables are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| word_i | input | W | Parallel conversion result |
| new_word_i | input | 1 | One-cycle strobe: a new result is present on `word_i` |
| clk_sel_i | input | 1 | Shift-clock source: 0 internal, 1 external |
| se_mode_i | input | 1 | Output standard: 1 single-ended, 0 differential |
| cs_ni | input | 1 | Chip select, active low |
| ext_sclk_i | input | 1 | Shift clock from the host |
| sdo_o | output | 1 | Serial data |
| sdo_n_o | output | 1 | Complement of serial data |
| sdo_oe_o | output | 1 | Driver enable for both data outputs |
| rdy_o | output | 1 | Result ready |
| rdy_n_o | output | 1 | Complement of result ready |
| sclk_o | output | 1 | Internally generated shift clock |
| sclk_oe_o | output | 1 | Driver enable for the shift-clock output |

## Verification
The bench acts as the host. It reassembles each word by sampling `sdo_o` at the rising edges it sees on `sclk_o`, or at the rising edges it drives itself on `ext_sclk_i`.

Faults in the internal state show up at the ports within one shift period:
- A bit counter that is off by one shows as a `rdy_o` fall one period early or late.
- Shift-register misordering corrupts the reassembled word.
- A bit position that is not restored under chip select makes the word resent after reselection start mid-word.
- A missed re-arm after a discarded word leaves `rdy_o` stuck low, or removes the one-cycle low pulse.

// File: rtl/adc_sout_pkg.sv
package adc_sout_pkg;
  typedef enum logic {
    SRC_INT = 1'b0,
    SRC_EXT = 1'b1
  } sclk_src_e;
endpackage

// File: rtl/adc_sout_clkgen.sv
module adc_sout_clkgen import adc_sout_pkg::*; #(
  parameter int DIV = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic clk_sel_i,
  input  logic se_mode_i,
  input  logic ext_sclk_i,
  output logic sclk_o,
  output logic int_src_o,
  output logic fall_o
);
  localparam int HALF = DIV / 2;
  localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

  sclk_src_e src;
  logic [CW-1:0] div_cnt;
  logic          sclk_q;
  logic          tick;
  logic [2:0]    ext_sync;
  logic          ext_fall;

  // differential mode forces the internal source
  assign src       = (se_mode_i && clk_sel_i) ? SRC_EXT : SRC_INT;
  assign int_src_o = (src == SRC_INT);
  assign tick      = (div_cnt == CW'(HALF - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_cnt <= '0;
      sclk_q  <= 1'b0;
    end else if (cs_ni || !int_src_o) begin
      div_cnt <= '0;
      sclk_q  <= 1'b0;
    end else if (tick) begin
      div_cnt <= '0;
      sclk_q  <= ~sclk_q;
    end else begin
      div_cnt <= div_cnt + CW'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ext_sync <= '0;
    else         ext_sync <= {ext_sync[1:0], ext_sclk_i};
  end

  assign ext_fall = ext_sync[2] & ~ext_sync[1];
  assign sclk_o   = int_src_o ? sclk_q : 1'b0;
  assign fall_o   = int_src_o ? (tick & sclk_q & ~cs_ni) : (ext_fall & ~cs_ni);

  a_r5_cs_holds_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> !sclk_q);
  a_r2_div_period: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_ni && int_src_o && !tick) |=> $stable(sclk_q));
endmodule

// File: rtl/adc_sout_shifter.sv
module adc_sout_shifter #(
  parameter int W = 24
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] word_i,
  input  logic         new_word_i,
  input  logic         cs_ni,
  input  logic         fall_i,
  output logic         sdo_o,
  output logic         rdy_o
);
  localparam int NW = $clog2(W + 1);

  logic [W-1:0]  word_q;
  logic [W-1:0]  shreg;
  logic [NW-1:0] bits_left;
  logic          rdy_q;
  logic          relaunch;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q    <= '0;
      shreg     <= '0;
      bits_left <= '0;
      rdy_q     <= 1'b0;
      relaunch  <= 1'b0;
    end else if (new_word_i) begin
      word_q    <= word_i;
      shreg     <= word_i;
      bits_left <= NW'(W);
      // re-arm through a one-cycle low so the host sees a fresh rising edge
      rdy_q     <= ~rdy_q;
      relaunch  <= rdy_q;
    end else if (relaunch) begin
      rdy_q    <= 1'b1;
      relaunch <= 1'b0;
    end else if (cs_ni) begin
      shreg     <= word_q;
      bits_left <= NW'(W);
    end else if (fall_i && rdy_q) begin
      if (bits_left == NW'(1)) begin
        rdy_q     <= 1'b0;
        bits_left <= '0;
      end else begin
        shreg     <= {shreg[W-2:0], 1'b0};
        bits_left <= bits_left - NW'(1);
      end
    end
  end

  assign sdo_o = shreg[W-1];
  assign rdy_o = rdy_q;

  a_r7_load_msb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (new_word_i && !rdy_q) |=> (rdy_q && sdo_o == $past(word_i[W-1])));
  a_r9_relaunch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (new_word_i && rdy_q) |=> !rdy_q ##1 rdy_q);
  a_r1_shift_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fall_i && rdy_q && !relaunch && !new_word_i && !cs_ni && bits_left > NW'(1))
      |=> sdo_o == $past(shreg[W-2]));
  a_r8_last_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fall_i && rdy_q && !relaunch && !new_word_i && !cs_ni && bits_left == NW'(1))
      |=> !rdy_q);
endmodule

// File: rtl/adc_sout_if.sv
module adc_sout_if #(
  parameter int W   = 24,
  parameter int DIV = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] word_i,
  input  logic         new_word_i,
  input  logic         clk_sel_i,
  input  logic         se_mode_i,
  input  logic         cs_ni,
  input  logic         ext_sclk_i,
  output logic         sdo_o,
  output logic         sdo_n_o,
  output logic         sdo_oe_o,
  output logic         rdy_o,
  output logic         rdy_n_o,
  output logic         sclk_o,
  output logic         sclk_oe_o
);
  logic int_src;
  logic fall;
  logic sdo;
  logic rdy;

  adc_sout_clkgen #(.DIV(DIV)) u_clkgen (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cs_ni      (cs_ni),
    .clk_sel_i  (clk_sel_i),
    .se_mode_i  (se_mode_i),
    .ext_sclk_i (ext_sclk_i),
    .sclk_o     (sclk_o),
    .int_src_o  (int_src),
    .fall_o     (fall)
  );

  adc_sout_shifter #(.W(W)) u_shifter (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .word_i     (word_i),
    .new_word_i (new_word_i),
    .cs_ni      (cs_ni),
    .fall_i     (fall),
    .sdo_o      (sdo),
    .rdy_o      (rdy)
  );

  assign sdo_o     = sdo;
  assign sdo_n_o   = ~sdo;
  assign rdy_o     = rdy;
  assign rdy_n_o   = ~rdy;
  assign sdo_oe_o  = ~cs_ni;
  assign sclk_oe_o = ~cs_ni & int_src;

  a_r3_ext_no_drive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (se_mode_i && clk_sel_i) |-> !sclk_oe_o);
  a_r5_cs_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_ni && $past(cs_ni)) |-> !sclk_o);
endmodule

// File: tb/adc_sout_if_tb_top.sv
`timescale 1ns/1ps
module adc_sout_if_tb_top;
  localparam int W   = 24;
  localparam int DIV = 2;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic [W-1:0] word_i = '0;
  logic         new_word_i = 1'b0;
  logic         clk_sel_i = 1'b0;
  logic         se_mode_i = 1'b1;
  logic         cs_ni = 1'b1;
  logic         ext_sclk_i = 1'b0;
  logic sdo_o, sdo_n_o, sdo_oe_o, rdy_o, rdy_n_o, sclk_o, sclk_oe_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  adc_sout_if #(.W(W), .DIV(DIV)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .word_i(word_i), .new_word_i(new_word_i),
    .clk_sel_i(clk_sel_i), .se_mode_i(se_mode_i), .cs_ni(cs_ni),
    .ext_sclk_i(ext_sclk_i), .sdo_o(sdo_o), .sdo_n_o(sdo_n_o),
    .sdo_oe_o(sdo_oe_o), .rdy_o(rdy_o), .rdy_n_o(rdy_n_o),
    .sclk_o(sclk_o), .sclk_oe_o(sclk_oe_o)
  );

  task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic strobe(input logic [W-1:0] w);
    @(negedge clk);
    word_i = w;
    new_word_i = 1'b1;
    @(negedge clk);
    new_word_i = 1'b0;
  endtask

  // host side: sample data on each rising edge of the internal clock
  task automatic cap_int(input int n, output logic [W-1:0] val);
    logic prev = sclk_o;
    int got = 0;
    val = '0;
    while (got < n) begin
      @(negedge clk);
      if (!prev && sclk_o) begin
        val = {val[W-2:0], sdo_o};
        got++;
        if (got == 1) check(sdo_n_o == ~sdo_o, "R6 sdo_n", W'(sdo_n_o), W'(~sdo_o));
      end
      prev = sclk_o;
    end
  endtask

  task automatic cap_ext(input int n, output logic [W-1:0] val);
    val = '0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      val = {val[W-2:0], sdo_o};
      ext_sclk_i = 1'b1;
      cyc(4);
      ext_sclk_i = 1'b0;
      cyc(6);
    end
  endtask

  function automatic int exp_toggles(input int cycles);
    return cycles / (DIV / 2);
  endfunction

  initial begin
    int seed;
    logic [W-1:0] w, w2, got;
    seed = $urandom(32'd2024);
    cyc(3);
    rst_ni = 1'b1;
    cyc(1);
    // R10 reset state
    check(rdy_o == 1'b0, "R10 rdy", W'(rdy_o), '0);
    check(rdy_n_o == 1'b1, "R10 rdy_n", W'(rdy_n_o), W'(1));
    check(sclk_o == 1'b0, "R10 sclk", W'(sclk_o), '0);
    check(!sdo_oe_o && !sclk_oe_o, "R10 oe", W'({sdo_oe_o, sclk_oe_o}), '0);

    // internal clock, both modes
    for (int t = 0; t < 6; t++) begin
      se_mode_i = (t < 3);
      clk_sel_i = (t < 3) ? 1'b0 : 1'($urandom);
      w = W'($urandom);
      if (t == 0) w = {1'b1, {(W-1){1'b0}}};
      if (t == 1) w = {{(W-1){1'b0}}, 1'b1};
      strobe(w);
      check(rdy_o == 1'b1, "R7 rdy rise", W'(rdy_o), W'(1));
      check(sdo_o == w[W-1], "R7 msb", W'(sdo_o), W'(w[W-1]));
      cs_ni = 1'b0;
      cap_int(W, got);
      check(sclk_oe_o == 1'b1, t < 3 ? "R2 sclk_oe" : "R4 forced internal", W'(sclk_oe_o), W'(1));
      check(got == w, "R1 word", got, w);
      cyc(2 * DIV);
      check(rdy_o == 1'b0, "R8 rdy fall", W'(rdy_o), '0);
      @(negedge clk);
      cs_ni = 1'b1;
      cyc(2);
      check(!sdo_oe_o && !sclk_oe_o && sclk_o == 1'b0, "R5 tristate",
            W'({sdo_oe_o, sclk_oe_o, sclk_o}), '0);
      check(rdy_n_o == ~rdy_o, "R6 rdy_n", W'(rdy_n_o), W'(~rdy_o));
    end

    // R2 divider rate
    se_mode_i = 1'b1; clk_sel_i = 1'b0;
    cs_ni = 1'b0;
    cyc(4);
    begin
      int tog = 0;
      logic p = sclk_o;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        if (sclk_o != p) tog++;
        p = sclk_o;
      end
      check(tog == exp_toggles(20), "R2 toggles", W'(tog), W'(exp_toggles(20)));
    end
    cs_ni = 1'b1;
    cyc(2);

    // R3 external clock
    se_mode_i = 1'b1; clk_sel_i = 1'b1;
    for (int t = 0; t < 3; t++) begin
      w = W'($urandom);
      strobe(w);
      cs_ni = 1'b0;
      cyc(2);
      check(sclk_oe_o == 1'b0, "R3 sclk_oe", W'(sclk_oe_o), '0);
      check(sdo_oe_o == 1'b1, "R5 sdo_oe", W'(sdo_oe_o), W'(1));
      cap_ext(W, got);
      check(got == w, "R3 word", got, w);
      check(rdy_o == 1'b0, "R8 ext rdy fall", W'(rdy_o), '0);
      cs_ni = 1'b1;
      cyc(2);
    end

    // R5 restart from MSB after deselect
    se_mode_i = 1'b1; clk_sel_i = 1'b0;
    w = W'($urandom);
    strobe(w);
    cs_ni = 1'b0;
    cap_int(7, got);
    @(negedge clk);
    cs_ni = 1'b1;
    cyc(3);
    check(rdy_o == 1'b1, "R6 rdy held under cs", W'(rdy_o), W'(1));
    cs_ni = 1'b0;
    cap_int(W, got);
    check(got == w, "R5 restart", got, w);
    cyc(2 * DIV);
    cs_ni = 1'b1;
    cyc(2);

    // R9 discard unfinished word
    w = W'($urandom);
    w2 = ~w;
    strobe(w);
    cs_ni = 1'b0;
    cap_int(5, got);
    @(negedge clk);
    word_i = w2;
    new_word_i = 1'b1;
    @(negedge clk);
    new_word_i = 1'b0;
    check(rdy_o == 1'b0, "R9 low pulse", W'(rdy_o), '0);
    @(negedge clk);
    check(rdy_o == 1'b1, "R9 re-rise", W'(rdy_o), W'(1));
    cs_ni = 1'b1;
    cyc(2);
    cs_ni = 1'b0;
    cap_int(W, got);
    check(got == w2, "R9 new word", got, w2);
    cyc(2 * DIV);
    check(rdy_o == 1'b0, "R8 after relaunch", W'(rdy_o), '0);
    cs_ni = 1'b1;
    cyc(2);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule